// File: doc/BRIEF.md
# Non-Overlapping System Bus Handshake Controller

This block is the processor-side controller for a shared bus made of a multiplexed address/data path and a separate command path. It takes single read or write requests from an internal request port and turns them into bus cycles. At most one request is outstanding at a time, and a new one is refused until the previous one has completed.

A write goes out as an address cycle followed by a data cycle, and the bus stays with the processor. A read goes out as an address cycle, and then the controller gives the bus to the external agent so that the agent can send the reply. An external agent can also ask for the bus with an active-low request line. While the agent owns the bus, the controller treats every cycle in which the active-low valid-in strobe is low as a command or data beat, and hands that beat to the internal side.

Whenever bus ownership changes, the controller inserts one cycle in which all of its drivers are off.

Top module: `sysbus_hs_ctrl`

## Requirements
- R1: After reset, release_n and valid_out_n are high, the drivers are enabled, req_ready is high, and req_done and slv_valid are low.
- R2: When a write is accepted (req_valid and req_ready high at a clock edge), the next cycle drives the address with command 2 and valid_out_n low. The cycle after that drives the write data with command 3 and valid_out_n low. req_done pulses high for one cycle in the cycle after that, with release_n still high.
- R3: When a read is accepted, the next cycle drives the address with command 1 and valid_out_n low. In the cycle after that, the drivers are off, valid_out_n is high and release_n is low.
- R4: While a read is pending in slave state, the first valid-in-low cycle that carries command 4 is the reply. Its bus data appears on req_rdata, with req_done high, in the following cycle, and it produces no slv_valid.
- R5: If ext_rqst_n is low while the controller is idle as master, the next cycle has release_n low, the drivers off and valid_out_n high.
- R6: In slave state, each valid-in-low cycle that is not a read reply gives a one-cycle slv_valid pulse in the next cycle, carrying that cycle's command and data. Cycles with valid_in_n high give no pulse. valid_in_n is ignored while the processor owns the bus.
- R7: In slave state, with no read pending, a cycle with both ext_rqst_n and valid_in_n high makes the next cycle have release_n high with the drivers still off. The cycle after that has the drivers on again. A valid-in-low cycle delays this return.
- R8: req_ready is low from the cycle after an acceptance until the bus is back to idle master state. req_valid is ignored while req_ready is low.
- R9: valid_out_n is low only in cycles where the drivers are enabled and release_n is high.
- R10: If ext_rqst_n is low in idle master state, req_ready is low in that same cycle, so the external request takes priority over a simultaneous internal request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Internal request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read reply data, valid with req_done after a read |
| slv_valid | output | 1 | One-cycle pulse: beat captured from external agent |
| slv_cmd | output | CW | Command of the captured beat |
| slv_data | output | DW | Data of the captured beat |
| ext_rqst_n | input | 1 | External agent asks for the bus (active low) |
| release_n | output | 1 | Bus handed to external agent (active low) |
| valid_out_n | output | 1 | Processor drives a valid beat (active low) |
| valid_in_n | input | 1 | External agent drives a valid beat (active low) |
| ad_o | output | DW | Address/data bus out |
| ad_i | input | DW | Address/data bus in |
| ad_oe | output | 1 | Address/data driver enable |
| cmd_o | output | CW | Command bus out |
| cmd_i | input | CW | Command bus in |
| cmd_oe | output | 1 | Command driver enable |

## Verification
Every bus output comes straight from the state register, so it changes exactly one edge after the input that caused it. The address cycle follows acceptance by one edge, the write data cycle by two and the completion pulse by three. The read turnaround follows the address cycle by one edge. A reply or slave beat shows up one edge after its valid-in cycle. The return to master takes one edge to deassert release and a second edge to re-enable the drivers.

The bench drives inputs on the falling edge and checks outputs on the next falling edge, one rising edge later. It walks each sequence edge by edge, so every check lands on the cycle where its result is due. Expected commands and data come from bench functions.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  localparam int CW = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_TOSLV, ST_SLAVE, ST_TOMST
  } sbh_state_e;

  localparam logic [CW-1:0] CMD_NONE  = 4'd0;
  localparam logic [CW-1:0] CMD_RD    = 4'd1;
  localparam logic [CW-1:0] CMD_WR    = 4'd2;
  localparam logic [CW-1:0] CMD_WDATA = 4'd3;
  localparam logic [CW-1:0] CMD_RDATA = 4'd4;

  function automatic logic [CW-1:0] addr_cmd(input logic wr);
    return wr ? CMD_WR : CMD_RD;
  endfunction

  function automatic logic is_master(input sbh_state_e s);
    return (s == ST_IDLE) || (s == ST_ADDR) || (s == ST_WDATA);
  endfunction

  function automatic logic is_released(input sbh_state_e s);
    return (s == ST_TOSLV) || (s == ST_SLAVE);
  endfunction
endpackage

// File: rtl/sbh_fsm.sv
module sbh_fsm
  import sbh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       ext_rqst_n,
  input  logic       valid_in_n,
  input  logic       reply_hit,
  output sbh_state_e state,
  output logic       rd_pend,
  output logic       accept,
  output logic       wr_done
);
  sbh_state_e nxt;
  logic       wr_q;
  logic       may_return;

  assign accept     = (state == ST_IDLE) && ext_rqst_n && req_valid;
  assign wr_done    = (state == ST_WDATA);
  assign may_return = !rd_pend && ext_rqst_n && valid_in_n;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (!ext_rqst_n) nxt = ST_TOSLV;
                else if (req_valid) nxt = ST_ADDR;
      ST_ADDR:  nxt = wr_q ? ST_WDATA : ST_TOSLV;
      ST_WDATA: nxt = ST_IDLE;
      ST_TOSLV: nxt = ST_SLAVE;
      ST_SLAVE: if (may_return) nxt = ST_TOMST;
      ST_TOMST: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      rd_pend <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) wr_q <= req_write;
      if (state == ST_ADDR && !wr_q) rd_pend <= 1'b1;
      else if (reply_hit)            rd_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/sbh_master_drv.sv
module sbh_master_drv
  import sbh_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sbh_state_e    state,
  input  logic          accept,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] ad_o,
  output logic [CW-1:0] cmd_o,
  output logic          drv_en,
  output logic          valid_out_n,
  output logic          release_n
);
  logic [DW-1:0] addr_q, data_q;
  logic          wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_wdata;
      wr_q   <= req_write;
    end
  end

  assign drv_en    = is_master(state);
  assign release_n = !is_released(state);

  always_comb begin
    ad_o        = '0;
    cmd_o       = CMD_NONE;
    valid_out_n = 1'b1;
    if (state == ST_ADDR) begin
      ad_o        = addr_q;
      cmd_o       = addr_cmd(wr_q);
      valid_out_n = 1'b0;
    end else if (state == ST_WDATA) begin
      ad_o        = data_q;
      cmd_o       = CMD_WDATA;
      valid_out_n = 1'b0;
    end
  end
endmodule

// File: rtl/sbh_slave_cap.sv
module sbh_slave_cap
  import sbh_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sbh_state_e    state,
  input  logic          rd_pend,
  input  logic          wr_done,
  input  logic          valid_in_n,
  input  logic [DW-1:0] ad_i,
  input  logic [CW-1:0] cmd_i,
  output logic          reply_hit,
  output logic          slv_valid,
  output logic [CW-1:0] slv_cmd,
  output logic [DW-1:0] slv_data,
  output logic          req_done,
  output logic [DW-1:0] req_rdata
);
  logic beat;

  assign beat      = (state == ST_SLAVE) && !valid_in_n;
  assign reply_hit = beat && rd_pend && (cmd_i == CMD_RDATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slv_valid <= 1'b0;
      slv_cmd   <= CMD_NONE;
      slv_data  <= '0;
      req_done  <= 1'b0;
      req_rdata <= '0;
    end else begin
      slv_valid <= beat && !reply_hit;
      req_done  <= reply_hit || wr_done;
      if (beat && !reply_hit) begin
        slv_cmd  <= cmd_i;
        slv_data <= ad_i;
      end
      if (reply_hit) req_rdata <= ad_i;
    end
  end
endmodule

// File: rtl/sysbus_hs_ctrl.sv
module sysbus_hs_ctrl
  import sbh_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          req_done,
  output logic [DW-1:0] req_rdata,
  output logic          slv_valid,
  output logic [CW-1:0] slv_cmd,
  output logic [DW-1:0] slv_data,
  input  logic          ext_rqst_n,
  output logic          release_n,
  output logic          valid_out_n,
  input  logic          valid_in_n,
  output logic [DW-1:0] ad_o,
  input  logic [DW-1:0] ad_i,
  output logic          ad_oe,
  output logic [CW-1:0] cmd_o,
  input  logic [CW-1:0] cmd_i,
  output logic          cmd_oe
);
  sbh_state_e state;
  logic       rd_pend, accept, wr_done, reply_hit, drv_en;

  assign req_ready = (state == ST_IDLE) && ext_rqst_n;
  assign ad_oe     = drv_en;
  assign cmd_oe    = drv_en;

  sbh_fsm i_fsm (
    .clk, .rst_n, .req_valid, .req_write, .ext_rqst_n, .valid_in_n,
    .reply_hit, .state, .rd_pend, .accept, .wr_done
  );

  sbh_master_drv #(.DW(DW)) i_drv (
    .clk, .rst_n, .state, .accept, .req_write, .req_addr, .req_wdata,
    .ad_o, .cmd_o, .drv_en, .valid_out_n, .release_n
  );

  sbh_slave_cap #(.DW(DW)) i_cap (
    .clk, .rst_n, .state, .rd_pend, .wr_done, .valid_in_n, .ad_i, .cmd_i,
    .reply_hit, .slv_valid, .slv_cmd, .slv_data, .req_done, .req_rdata
  );
endmodule

// File: rtl/sbh_checker.sv
module sbh_checker
  import sbh_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_done,
  input logic          ext_rqst_n,
  input logic          release_n,
  input logic          valid_out_n,
  input logic          ad_oe,
  input logic          cmd_oe,
  input logic [CW-1:0] cmd_o
);
  // R9: valid strobe only while owning and driving
  a_r9_vout_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out_n |-> (ad_oe && cmd_oe && release_n));

  // R2: write data cycle follows the write address cycle
  a_r2_wdata_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_out_n && cmd_o == CMD_WR) |=> (!valid_out_n && cmd_o == CMD_WDATA));

  // R3: read address cycle is followed by release with drivers off
  a_r3_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_out_n && cmd_o == CMD_RD) |=> (!ad_oe && !release_n));

  // R5: grant and return both pass through a cycle with drivers off
  a_r5_grant_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(release_n) |-> (!ad_oe && !cmd_oe));
  a_r7_return_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_n) |-> !ad_oe);
  a_r7_drive_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(release_n));

  // R8: one outstanding request, single-cycle done
  a_r8_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  // R10: external request blocks acceptance
  a_r10_ext_priority: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rqst_n |-> !req_ready);
endmodule

bind sysbus_hs_ctrl sbh_checker #(.DW(DW)) i_chk (
  .clk, .rst_n, .req_valid, .req_ready, .req_done, .ext_rqst_n, .release_n,
  .valid_out_n, .ad_oe, .cmd_oe, .cmd_o
);

// File: tb/test_sysbus_hs_ctrl.sv
module test_sysbus_hs_ctrl;
  localparam int DW = 32;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [DW-1:0] req_addr = '0, req_wdata = '0, req_rdata, slv_data, ad_o;
  logic [DW-1:0] ad_i = '0;
  logic req_ready, req_done, slv_valid, release_n, valid_out_n, ad_oe, cmd_oe;
  logic ext_rqst_n = 1, valid_in_n = 1;
  logic [CW-1:0] slv_cmd, cmd_o, cmd_i = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  sysbus_hs_ctrl #(.DW(DW)) i_sysbus_hs_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_ready,
    .req_done, .req_rdata, .slv_valid, .slv_cmd, .slv_data, .ext_rqst_n,
    .release_n, .valid_out_n, .valid_in_n, .ad_o, .ad_i, .ad_oe, .cmd_o,
    .cmd_i, .cmd_oe
  );

  function automatic logic [CW-1:0] exp_addr_cmd(input logic wr);
    return wr ? 4'd2 : 4'd1;
  endfunction
  function automatic logic [CW-1:0] exp_wdata_cmd();
    return 4'd3;
  endfunction
  function automatic logic [CW-1:0] exp_reply_cmd();
    return 4'd4;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d);
    chk(req_ready == 1, "R8 ready idle", req_ready, 1);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    step();
    req_valid = 0;
    chk(valid_out_n == 0 && ad_o == a && cmd_o == exp_addr_cmd(1) && ad_oe,
        "R2 addr cycle", {cmd_o, ad_o}, {exp_addr_cmd(1), a});
    chk(req_ready == 0, "R8 busy", req_ready, 0);
    step();
    chk(valid_out_n == 0 && ad_o == d && cmd_o == exp_wdata_cmd(),
        "R2 data cycle", {cmd_o, ad_o}, {exp_wdata_cmd(), d});
    step();
    chk(req_done == 1 && release_n == 1 && ad_oe == 1 && valid_out_n == 1,
        "R2 done", {req_done, release_n, ad_oe}, 3'b111);
    step();
    chk(req_done == 0, "R2 done one cycle", req_done, 0);
  endtask

  // noise beats in slave; pass expected slave capture each cycle (R6)
  task automatic slave_beats(input int n, input logic allow_reply_cmd);
    for (int i = 0; i < n; i++) begin
      logic       b = 1'($urandom % 2);
      logic [CW-1:0] c = 4'($urandom % 16);
      logic [DW-1:0] v = $urandom;
      if (!allow_reply_cmd && c == exp_reply_cmd()) c = 4'd7;
      valid_in_n = !b; cmd_i = c; ad_i = v;
      step();
      chk(slv_valid == b, "R6 slave beat", slv_valid, b);
      if (b) chk(slv_data == v && slv_cmd == c, "R6 slave data",
                 {slv_cmd, slv_data}, {c, v});
      chk(release_n == 0 && ad_oe == 0, "R7 stays slave", {release_n, ad_oe}, 0);
      chk(req_done == 0, "R4 no early done", req_done, 0);
    end
    valid_in_n = 1;
  endtask

  task automatic return_master();
    step();
    chk(release_n == 1 && ad_oe == 0 && cmd_oe == 0, "R7 release gap",
        {release_n, ad_oe}, 2'b10);
    step();
    chk(ad_oe == 1 && req_ready == 1, "R7 drivers back", {ad_oe, req_ready}, 2'b11);
  endtask

  task automatic do_read(input logic [DW-1:0] a, input logic [DW-1:0] d,
                         input int lat);
    req_valid = 1; req_write = 0; req_addr = a;
    step();
    req_valid = 0;
    chk(valid_out_n == 0 && ad_o == a && cmd_o == exp_addr_cmd(0),
        "R3 addr cycle", {cmd_o, ad_o}, {exp_addr_cmd(0), a});
    step();
    chk(ad_oe == 0 && release_n == 0 && valid_out_n == 1, "R3 release",
        {ad_oe, release_n, valid_out_n}, 3'b001);
    step();
    slave_beats(lat, 1'b0);
    valid_in_n = 0; cmd_i = exp_reply_cmd(); ad_i = d;
    step();
    valid_in_n = 1;
    chk(req_done == 1 && req_rdata == d, "R4 reply", req_rdata, d);
    chk(slv_valid == 0, "R4 reply not slave beat", slv_valid, 0);
    return_master();
  endtask

  task automatic ext_session(input int n);
    ext_rqst_n = 0; req_valid = 1; req_write = 1;
    #1;
    chk(req_ready == 0, "R10 ext priority", req_ready, 0);
    step();
    chk(release_n == 0 && ad_oe == 0 && valid_out_n == 1, "R5 grant",
        {release_n, ad_oe, valid_out_n}, 3'b001);
    step();
    chk(valid_out_n == 1, "R8 req ignored in slave", valid_out_n, 1);
    req_valid = 0;
    slave_beats(n, 1'b1);
    // drop request together with a beat: return must wait (R7)
    ext_rqst_n = 1; valid_in_n = 0; cmd_i = 4'd9; ad_i = 32'hC0DE_0009;
    step();
    valid_in_n = 1;
    chk(release_n == 0 && slv_valid == 1, "R7 beat delays return",
        {release_n, slv_valid}, 2'b01);
    return_master();
  endtask

  initial begin
    int unused = $urandom(32'd20240611);
    @(negedge clk); step();
    chk(release_n == 1 && valid_out_n == 1 && ad_oe == 1 && req_ready == 1 &&
        req_done == 0 && slv_valid == 0, "R1 reset state",
        {release_n, valid_out_n, ad_oe, req_ready, req_done, slv_valid}, 6'b111100);
    rst_n = 1;
    step();
    // master-state valid_in ignored (R6)
    valid_in_n = 0; cmd_i = 4'd5; ad_i = 32'h1234;
    step(); step();
    chk(slv_valid == 0 && ad_oe == 1, "R6 ignored as master", slv_valid, 0);
    valid_in_n = 1;
    do_write(32'h0000_1000, 32'hDEAD_BEEF);
    do_read(32'h0000_2000, 32'hCAFE_F00D, 0);
    do_read(32'hFFFF_FFFC, 32'h0, 3);
    ext_session(0);
    ext_session(4);
    for (int k = 0; k < 300; k++) begin
      case ($urandom % 3)
        0: do_write($urandom, $urandom);
        1: do_read($urandom, $urandom, int'($urandom % 5));
        default: ext_session(int'($urandom % 5));
      endcase
    end
    summary();
  end
endmodule